// File: doc/BRIEF.md
# Multi-channel reloading down-counter timer

This block is a memory-mapped timer with two or three independent 32-bit channels. A shared run register holds one bit per channel. Each channel has a reload constant, a down-counter and a 16-bit control word. While a channel runs, its counter steps down once per prescaled tick. The tick rate is the peripheral clock divided by 4, 16, 64, 256 or 1024.

When a counter steps past zero it takes its value from the reload constant and raises a sticky underflow flag. The flag drives the channel's interrupt line when that line is enabled. Software picks the event type through the reload value alone. An all-ones constant gives a free-running timebase. A smaller constant gives a periodic event. For a one-shot, software clears the enable after the first event.

Software reaches the registers through a plain register bus. The bus takes one-, two- and four-byte accesses. A parameter picks one of two address layouts. A read is combinational, and a write takes effect at the clock edge on which the write strobe is high.

Top module: `mct_timer`

## Requirements
- R1: Bit n of the run register starts channel n when it is 1 and stops it when it is 0. A run write leaves every other bit of state alone. Bits n >= NCH read as 0. The run register sits at byte 4, or at byte 2 when LEGACY_MAP=1.
- R2: With LEGACY_MAP=0, channel n starts at byte 8+12n. Its reload constant is at +0, its counter at +4 and its control word at +8. All registers are little-endian. `bus_size` 0, 1 and 2 select a 1-, 2- or 4-byte access at `bus_addr`. A write changes only the register bytes it covers. Read data is right-aligned, and bytes that hit no register read 0. After reset the constant and counter read 0xFFFFFFFF, and the control word and run register read 0.
- R3: Control bits [2:0] select the tick divider: code 0 is /4, 1 is /16, 2 is /64, 3 is /256 and 4 is /1024. Codes 5 to 7 act as /4. The first decrement comes exactly DIV clock edges after the edge that sets the run bit.
- R4: A running counter drops by one on each tick. A stopped counter holds its value.
- R5: A tick that finds the counter at 0 loads the reload constant and sets the underflow flag, control bit 8.
- R6: The underflow flag stays set until a write puts 0 in bit 8. Writing 1 to bit 8 leaves the flag unchanged.
- R7: `irq[n]` is high exactly when channel n's flag and its interrupt enable (control bit 5) are both 1. The line is a level.
- R8: A counter write lands on the next edge even while the channel runs. If it coincides with a tick, the write wins, and the following decrement starts from the written value.
- R9: With LEGACY_MAP=1 the run register is at byte 2 and channel n starts at byte 4+12n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_size | input | 2 | Access size: 0 byte, 1 halfword, 2 word |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data, right-aligned |
| bus_rdata | output | 32 | Read data, right-aligned, combinational |
| irq | output | NCH | Per-channel interrupt level |

## Verification
Some behaviour is checked by the embedded properties on every cycle. They cover the single-step decrement, the hold while stopped, the reload with flag set at zero, the flag's stickiness, the run register's stability when it is not written, and the gap of at least one idle cycle between prescaler ticks. The properties cannot see absolute divider ratios, byte-lane placement, legacy addresses or a write winning against a tick. The bench's scenarios show these, together with a behavioural model compared on every clock.

// File: rtl/mct_pkg.sv
package mct_pkg;

    localparam int unsigned WORD_W   = 32;
    localparam int unsigned CTL_W    = 16;
    localparam int unsigned STRIDE   = 12;
    localparam int unsigned DIV_TOP  = 1024;

    typedef enum logic [1:0] {
        ACC_BYTE = 2'd0,
        ACC_HALF = 2'd1,
        ACC_WORD = 2'd2
    } acc_size_e;

    typedef struct packed {
        logic       flag;
        logic       ien;
        logic [2:0] psel;
    } ctl_t;

    function automatic int unsigned acc_bytes(logic [1:0] sz);
        case (sz)
            ACC_BYTE: return 1;
            ACC_HALF: return 2;
            default:  return 4;
        endcase
    endfunction

    function automatic int unsigned div_ratio(logic [2:0] psel);
        case (psel)
            3'd1:    return 16;
            3'd2:    return 64;
            3'd3:    return 256;
            3'd4:    return 1024;
            default: return 4;
        endcase
    endfunction

    function automatic logic lane_hit(int unsigned reg_byte, int unsigned acc_addr,
                                      logic [1:0] sz);
        return (reg_byte >= acc_addr) && (reg_byte < acc_addr + acc_bytes(sz));
    endfunction

    function automatic logic [7:0] lane_pick(logic [31:0] data, int unsigned reg_byte,
                                             int unsigned acc_addr);
        logic [31:0] s;
        s = data >> (8 * ((reg_byte - acc_addr) & 3));
        return s[7:0];
    endfunction

    function automatic logic [31:0] lane_place(logic [7:0] b, int unsigned reg_byte,
                                               int unsigned acc_addr);
        return {24'd0, b} << (8 * ((reg_byte - acc_addr) & 3));
    endfunction

    function automatic logic [31:0] merge32(logic [31:0] old, logic [31:0] nw,
                                            logic [3:0] be);
        logic [31:0] r;
        r = old;
        for (int i = 0; i < 4; i++) begin
            if (be[i]) r[8*i +: 8] = nw[8*i +: 8];
        end
        return r;
    endfunction

    function automatic logic [15:0] ctl_pack(ctl_t c);
        return {7'd0, c.flag, 2'd0, c.ien, 2'd0, c.psel};
    endfunction

endpackage

// File: rtl/mct_prescaler.sv
module mct_prescaler
    import mct_pkg::*;
#(
    parameter int unsigned DIV_MAX = DIV_TOP
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       run,
    input  logic       restart,
    input  logic [2:0] psel,
    output logic       tick
);
    localparam int unsigned CW = $clog2(DIV_MAX);

    logic [CW-1:0] phase_q;
    logic [CW-1:0] limit;

    assign limit = CW'(div_ratio(psel) - 1);
    assign tick  = run && (phase_q >= limit);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= '0;
        end else if (restart) begin
            phase_q <= '0;
        end else if (run) begin
            phase_q <= tick ? '0 : phase_q + 1'b1;
        end
    end

    // R3: the smallest divider is 4, so two ticks are never adjacent
    p_tick_gap_r3: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);

endmodule

// File: rtl/mct_channel.sv
module mct_channel
    import mct_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        run,
    input  logic        restart,
    input  logic [3:0]  k_be,
    input  logic [31:0] k_wd,
    input  logic [3:0]  n_be,
    input  logic [31:0] n_wd,
    input  logic [1:0]  c_be,
    input  logic [15:0] c_wd,
    output logic [31:0] konst,
    output logic [31:0] count,
    output logic [15:0] ctl_word,
    output logic        irq
);
    logic        tick;
    logic        cnt_wr;
    logic        underflow;
    logic        flag_clr;
    ctl_t        ctl_q;
    logic        wd_unused;

    mct_prescaler #(.DIV_MAX(DIV_TOP)) u_presc (
        .clk     (clk),
        .rst     (rst),
        .run     (run),
        .restart (restart),
        .psel    (ctl_q.psel),
        .tick    (tick)
    );

    assign cnt_wr    = |n_be;
    assign underflow = tick && !cnt_wr && (count == '0);
    assign flag_clr  = c_be[1] && !c_wd[8];
    assign wd_unused = ^{c_wd[15:9], c_wd[7:6], c_wd[4:3]};

    always_ff @(posedge clk) begin
        if (rst) begin
            konst <= '1;
            count <= '1;
            ctl_q <= '0;
        end else begin
            konst <= merge32(konst, k_wd, k_be);
            if (cnt_wr) begin
                count <= merge32(count, n_wd, n_be);
            end else if (tick) begin
                count <= (count == '0) ? konst : count - 1'b1;
            end
            if (c_be[0]) begin
                ctl_q.psel <= c_wd[2:0];
                ctl_q.ien  <= c_wd[5];
            end
            if (underflow)      ctl_q.flag <= 1'b1;
            else if (flag_clr)  ctl_q.flag <= 1'b0;
        end
    end

    assign ctl_word = ctl_pack(ctl_q);
    assign irq      = ctl_q.flag & ctl_q.ien;

    // R4: a tick away from zero steps the counter by exactly one
    p_step_r4: assert property (@(posedge clk) disable iff (rst)
        (tick && !cnt_wr && count != '0) |=> count == $past(count) - 1);

    // R4: a stopped, unwritten counter holds
    p_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (!run && !cnt_wr) |=> $stable(count));

    // R5: a tick at zero reloads and raises the flag
    p_reload_r5: assert property (@(posedge clk) disable iff (rst)
        (tick && !cnt_wr && count == '0) |=> (count == $past(konst)) && ctl_word[8]);

    // R6: the flag only falls through a zero write to bit 8
    p_sticky_r6: assert property (@(posedge clk) disable iff (rst)
        (ctl_word[8] && !flag_clr) |=> ctl_word[8]);

endmodule

// File: rtl/mct_timer.sv
module mct_timer
    import mct_pkg::*;
#(
    parameter int unsigned NCH        = 3,
    parameter bit          LEGACY_MAP = 1'b0,
    parameter int unsigned ADDR_W     = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [1:0]        bus_size,
    input  logic              bus_wr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic [NCH-1:0]    irq
);
    localparam int unsigned RUN_OFS = LEGACY_MAP ? 2 : 4;
    localparam int unsigned CH0_OFS = LEGACY_MAP ? 4 : 8;

    initial begin
        assert (NCH == 2 || NCH == 3) else $error("NCH must be 2 or 3");
    end

    int unsigned acc;
    assign acc = 32'(bus_addr);

    logic [NCH-1:0] run_q;
    logic [NCH-1:0] run_d;
    logic           run_wr;
    logic [7:0]     run_wb;
    logic           run_unused;

    logic [3:0]  k_be [NCH];
    logic [31:0] k_wd [NCH];
    logic [3:0]  n_be [NCH];
    logic [31:0] n_wd [NCH];
    logic [1:0]  c_be [NCH];
    logic [15:0] c_wd [NCH];
    logic [31:0] k_q  [NCH];
    logic [31:0] n_q  [NCH];
    logic [15:0] c_q  [NCH];

    // write lane decode
    always_comb begin
        run_wr = bus_wr && lane_hit(RUN_OFS, acc, bus_size);
        run_wb = lane_pick(bus_wdata, RUN_OFS, acc);
        run_d  = run_wr ? run_wb[NCH-1:0] : run_q;
        for (int c = 0; c < NCH; c++) begin
            for (int i = 0; i < 4; i++) begin
                k_be[c][i]       = bus_wr && lane_hit(CH0_OFS + STRIDE*c + i, acc, bus_size);
                k_wd[c][8*i +: 8] = lane_pick(bus_wdata, CH0_OFS + STRIDE*c + i, acc);
                n_be[c][i]       = bus_wr && lane_hit(CH0_OFS + STRIDE*c + 4 + i, acc, bus_size);
                n_wd[c][8*i +: 8] = lane_pick(bus_wdata, CH0_OFS + STRIDE*c + 4 + i, acc);
            end
            for (int i = 0; i < 2; i++) begin
                c_be[c][i]       = bus_wr && lane_hit(CH0_OFS + STRIDE*c + 8 + i, acc, bus_size);
                c_wd[c][8*i +: 8] = lane_pick(bus_wdata, CH0_OFS + STRIDE*c + 8 + i, acc);
            end
        end
    end

    assign run_unused = ^run_wb;

    always_ff @(posedge clk) begin
        if (rst) run_q <= '0;
        else     run_q <= run_d;
    end

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        mct_channel u_ch (
            .clk      (clk),
            .rst      (rst),
            .run      (run_q[c]),
            .restart  (!run_q[c] && run_d[c]),
            .k_be     (k_be[c]),
            .k_wd     (k_wd[c]),
            .n_be     (n_be[c]),
            .n_wd     (n_wd[c]),
            .c_be     (c_be[c]),
            .c_wd     (c_wd[c]),
            .konst    (k_q[c]),
            .count    (n_q[c]),
            .ctl_word (c_q[c]),
            .irq      (irq[c])
        );
    end

    // read assembly
    always_comb begin
        bus_rdata = '0;
        if (lane_hit(RUN_OFS, acc, bus_size))
            bus_rdata = bus_rdata | lane_place(8'(run_q), RUN_OFS, acc);
        for (int c = 0; c < NCH; c++) begin
            for (int i = 0; i < 4; i++) begin
                if (lane_hit(CH0_OFS + STRIDE*c + i, acc, bus_size))
                    bus_rdata = bus_rdata |
                        lane_place(k_q[c][8*i +: 8], CH0_OFS + STRIDE*c + i, acc);
                if (lane_hit(CH0_OFS + STRIDE*c + 4 + i, acc, bus_size))
                    bus_rdata = bus_rdata |
                        lane_place(n_q[c][8*i +: 8], CH0_OFS + STRIDE*c + 4 + i, acc);
            end
            for (int i = 0; i < 2; i++) begin
                if (lane_hit(CH0_OFS + STRIDE*c + 8 + i, acc, bus_size))
                    bus_rdata = bus_rdata |
                        lane_place(c_q[c][8*i +: 8], CH0_OFS + STRIDE*c + 8 + i, acc);
            end
        end
    end

    // R1: run bits move only through a write to the run register
    p_run_hold_r1: assert property (@(posedge clk) disable iff (rst)
        !run_wr |=> $stable(run_q));

endmodule

// File: tb/mct_timer_tb_top.sv
`timescale 1ns/1ps
module mct_timer_tb_top;
    localparam int NCH = 3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [5:0]  bus_addr = '0;
    logic [1:0]  bus_size = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] rdata, rdata_l;
    logic [2:0]  irq;
    logic [1:0]  irq_l;
    bit          done = 1'b0;
    int          nchk = 0;
    int          nfail = 0;

    always #2 clk = ~clk;

    mct_timer #(.NCH(3), .LEGACY_MAP(1'b0), .ADDR_W(6)) dut_i (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_size(bus_size),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(rdata), .irq(irq));

    mct_timer #(.NCH(2), .LEGACY_MAP(1'b1), .ADDR_W(6)) dut_leg_i (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_size(bus_size),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(rdata_l), .irq(irq_l));

    // behavioural reference of the default-map instance
    logic [31:0] m_k [NCH];
    logic [31:0] m_n [NCH];
    logic [2:0]  m_ps [NCH];
    logic        m_ie [NCH];
    logic        m_fl [NCH];
    logic [2:0]  m_run;
    int          m_dc [NCH];

    function automatic int mdiv(logic [2:0] p);
        case (p)
            3'd1: return 16;
            3'd2: return 64;
            3'd3: return 256;
            3'd4: return 1024;
            default: return 4;
        endcase
    endfunction

    function automatic int nbytes(logic [1:0] sz);
        return (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
    endfunction

    function automatic logic [7:0] mbyte(int a);
        if (a == 4) return {5'd0, m_run};
        for (int c = 0; c < NCH; c++) begin
            int o;
            o = a - (8 + 12*c);
            if (o >= 0 && o < 4) return m_k[c][8*o +: 8];
            if (o >= 4 && o < 8) return m_n[c][8*(o-4) +: 8];
            if (o == 8) return {2'd0, m_ie[c], 2'd0, m_ps[c]};
            if (o == 9) return {7'd0, m_fl[c]};
        end
        return 8'd0;
    endfunction

    function automatic logic [31:0] mread(int a, logic [1:0] sz);
        logic [31:0] r;
        r = '0;
        for (int j = 0; j < nbytes(sz); j++) r[8*j +: 8] = mbyte(a + j);
        return r;
    endfunction

    logic        tk [NCH];
    logic        cw [NCH];
    logic        clr [NCH];
    logic        setf [NCH];
    logic [31:0] nk [NCH];
    logic [31:0] nn [NCH];
    logic [2:0]  nrun;

    always @(posedge clk) begin
        if (rst) begin
            for (int c = 0; c < NCH; c++) begin
                m_k[c] = '1; m_n[c] = '1; m_ps[c] = '0; m_ie[c] = 1'b0;
                m_fl[c] = 1'b0; m_dc[c] = 0;
            end
            m_run = '0;
        end else begin
            nrun = m_run;
            for (int c = 0; c < NCH; c++) begin
                tk[c]  = m_run[c] && (m_dc[c] >= mdiv(m_ps[c]) - 1);
                cw[c]  = 1'b0; clr[c] = 1'b0; setf[c] = 1'b0;
                nk[c]  = m_k[c]; nn[c] = m_n[c];
            end
            if (bus_wr) begin
                for (int j = 0; j < nbytes(bus_size); j++) begin
                    int a;
                    logic [7:0] d;
                    a = int'(bus_addr) + j;
                    d = bus_wdata[8*j +: 8];
                    if (a == 4) nrun = d[2:0];
                    for (int c = 0; c < NCH; c++) begin
                        int o;
                        o = a - (8 + 12*c);
                        if (o >= 0 && o < 4) nk[c][8*o +: 8] = d;
                        if (o >= 4 && o < 8) begin nn[c][8*(o-4) +: 8] = d; cw[c] = 1'b1; end
                        if (o == 8) begin m_ps[c] = d[2:0]; m_ie[c] = d[5]; end
                        if (o == 9 && !d[0]) clr[c] = 1'b1;
                    end
                end
            end
            for (int c = 0; c < NCH; c++) begin
                if (!cw[c] && tk[c]) begin
                    if (m_n[c] == 0) begin nn[c] = m_k[c]; setf[c] = 1'b1; end
                    else nn[c] = m_n[c] - 1;
                end
                m_fl[c] = setf[c] ? 1'b1 : (clr[c] ? 1'b0 : m_fl[c]);
                if (!m_run[c] && nrun[c]) m_dc[c] = 0;
                else if (m_run[c]) m_dc[c] = tk[c] ? 0 : m_dc[c] + 1;
                m_k[c] = nk[c]; m_n[c] = nn[c];
            end
            m_run = nrun;
        end
    end

    task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
        nchk++;
        if (got !== exp) begin
            nfail++;
            $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
        end
    endtask

    // cycle comparison against the model
    always @(negedge clk) begin
        if (!rst && !done) begin
            check("R2 rdata vs model", rdata, mread(int'(bus_addr), bus_size));
            for (int c = 0; c < NCH; c++)
                check("R7 irq vs model", 32'(irq[c]), 32'(m_fl[c] & m_ie[c]));
        end
    end

    task automatic wr(int a, logic [1:0] sz, logic [31:0] d);
        @(posedge clk); #1;
        bus_addr = 6'(a); bus_size = sz; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic rd(int a, logic [1:0] sz, logic [31:0] e, string tag);
        @(posedge clk); #1;
        bus_addr = 6'(a); bus_size = sz;
        @(negedge clk);
        check(tag, rdata, e);
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    endtask

    initial begin
        #400000;
        nfail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] v;
        int k;
        repeat (5) @(posedge clk);
        #1 rst = 1'b0;

        // reset state
        rd(4, 2'd0, 32'h0, "R1 reset run register");
        rd(8, 2'd2, 32'hFFFF_FFFF, "R2 reset constant");
        rd(12, 2'd2, 32'hFFFF_FFFF, "R2 reset counter");
        rd(16, 2'd1, 32'h0, "R2 reset control");
        check("R7 reset irq", 32'(irq), 32'h0);

        // channel 0: period 10 ticks at /4, interrupt enabled
        wr(8, 2'd2, 32'd9);
        wr(12, 2'd2, 32'd9);
        wr(16, 2'd1, 32'h0020);
        wr(4, 2'd0, 32'h01);
        bus_addr = 6'd12; bus_size = 2'd2;
        repeat (3) @(posedge clk);
        @(negedge clk); check("R3 no decrement before 4 edges", rdata, 32'd9);
        @(negedge clk); check("R3 first decrement on 4th edge", rdata, 32'd8);
        repeat (35) @(negedge clk);
        check("R4 counted down to zero", rdata, 32'd0);
        check("R7 irq low before underflow", 32'(irq[0]), 32'd0);
        @(negedge clk);
        check("R5 reload on underflow", rdata, 32'd9);
        check("R7 irq on flag and enable", 32'(irq[0]), 32'd1);
        rd(16, 2'd1, 32'h0120, "R5 flag bit 8 set");

        // flag clear rules
        wr(16, 2'd1, 32'h0120);
        rd(16, 2'd1, 32'h0120, "R6 writing 1 keeps flag");
        wr(16, 2'd1, 32'h0020);
        rd(16, 2'd1, 32'h0020, "R6 writing 0 clears flag");
        check("R7 irq falls with flag", 32'(irq[0]), 32'd0);

        // channel 1 with a reserved prescaler code, interrupt disabled
        wr(20, 2'd2, 32'd3);
        wr(24, 2'd2, 32'd3);
        wr(28, 2'd1, 32'h0005);
        wr(4, 2'd0, 32'h03);
        rd(4, 2'd0, 32'h03, "R1 both run bits set");
        repeat (20) @(posedge clk);
        rd(28, 2'd1, 32'h0105, "R3 reserved code divides by 4");
        check("R7 no irq without enable", 32'(irq[1]), 32'd0);

        // byte lanes on a stopped channel
        wr(4, 2'd0, 32'h01);
        wr(24, 2'd2, 32'h1122_3344);
        wr(25, 2'd0, 32'h0000_00AB);
        rd(24, 2'd2, 32'h1122_AB44, "R2 byte write merges one lane");
        rd(26, 2'd1, 32'h0000_1122, "R2 upper halfword right-aligned");
        rd(27, 2'd0, 32'h0000_0011, "R2 top byte right-aligned");
        repeat (50) @(posedge clk);
        rd(24, 2'd2, 32'h1122_AB44, "R4 stopped counter holds");

        // counter write while running
        wr(12, 2'd2, 32'h100);
        @(negedge clk);
        check("R8 running write lands at once", rdata, 32'h100);
        k = 0;
        while (rdata == 32'h100 && k < 8) begin @(negedge clk); k++; end
        check("R8 next decrement from written value", rdata, 32'hFF);

        // stop all, counter must freeze
        wr(4, 2'd0, 32'h00);
        @(posedge clk); #1 bus_addr = 6'd12; bus_size = 2'd2;
        @(negedge clk); v = rdata;
        repeat (30) @(negedge clk);
        check("R4 counter frozen after stop", rdata, v);

        // channel 2 at /1024, start with upper bits set
        wr(40, 2'd1, 32'h0004);
        wr(32, 2'd2, 32'd5);
        wr(36, 2'd2, 32'd5);
        wr(4, 2'd0, 32'hFF);
        bus_addr = 6'd36; bus_size = 2'd2;
        repeat (1023) @(posedge clk);
        @(negedge clk); check("R3 /1024 holds for 1023 edges", rdata, 32'd5);
        @(negedge clk); check("R3 /1024 decrements on edge 1024", rdata, 32'd4);
        rd(4, 2'd0, 32'h07, "R1 bits above NCH read 0");

        // legacy layout instance
        wr(2, 2'd0, 32'h03);
        @(negedge clk); check("R9 legacy run register at byte 2", rdata_l, 32'h03);
        wr(4, 2'd2, 32'hCAFE_0001);
        @(negedge clk); check("R9 legacy channel 0 constant at byte 4", rdata_l, 32'hCAFE_0001);

        finish_run();
    end

endmodule